// File: doc/BRIEF.md
# Dual-Clock Mailbox Bypass Pair

This block carries single command words between two ports that run on unrelated clocks, outside the data queue that the two ports normally share. Each direction has one word of storage. The A side posts to the forward box, and the B side fetches from it. The B side posts to the return box, and the A side fetches from it. Each port uses its normal transfer strobe (select, direction and enable) for these transfers. A separate mailbox-select input steers the transfer either to the queue or to the box.

Each box has an active-low "full" flag in the clock domain of the port that writes it. A posted word pulls the flag low. While the flag is low, further posts to that box are dropped. A fetch by the far port is sent back as a toggle through a synchronizer. The flag goes high again on the second edge of the writer's own clock after the fetch.

Each port's read data output also selects between the queue's output register and the box that port fetches from. The selection follows the port's mailbox select.

Top module: `mbx_bridge`

## Requirements
- R1: On a rising clk_a edge with a_sel_n low, a_en high, a_wr high (write) and a_mbx high, while a_mail_full_n is high, the forward box loads a_din and a_mail_full_n reads low after that edge.
- R2: On a rising clk_b edge with b_sel_n low, b_en high, b_rd_nwr low (write) and b_mbx high, while b_mail_full_n is high, the return box loads b_din and b_mail_full_n reads low after that edge.
- R3: A post to a box whose full flag is low leaves the box contents and the low flag unchanged.
- R4: A B-side fetch (b_sel_n low, b_en high, b_rd_nwr high, b_mbx high) leaves a_mail_full_n low after the first following clk_a edge. The flag reads high after the second following clk_a edge.
- R5: An A-side fetch (a_sel_n low, a_en high, a_wr low, a_mbx high) leaves b_mail_full_n low after the first following clk_b edge. The flag reads high after the second following clk_b edge.
- R6: With a_mbx low, a_dout equals a_fifo_q. With b_mbx low, b_dout equals b_fifo_q.
- R7: With a_mbx high, a_dout shows the return box. With b_mbx high, b_dout shows the forward box. A fetch leaves the box contents unchanged.
- R8: While reset is high, both flags go high and both boxes clear to zero. rst_a covers the forward box and rst_b covers the return box.
- R9: A strobe that has select high, enable low or mailbox select low, or that runs in the fetch direction, does not load the box of that port.
- R10: A post on the first writer edge at which the flag has returned high is accepted. The flag goes low again and stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | A-side clock |
| rst_a | input | 1 | A-side synchronous reset, active high |
| a_sel_n | input | 1 | A-side select, active low |
| a_wr | input | 1 | A-side direction, 1 = write |
| a_en | input | 1 | A-side transfer enable |
| a_mbx | input | 1 | A-side mailbox select |
| a_din | input | DATA_W | A-side write data |
| a_fifo_q | input | DATA_W | Queue output register for the A side |
| a_dout | output | DATA_W | A-side read data |
| a_mail_full_n | output | 1 | Forward box full flag, active low |
| clk_b | input | 1 | B-side clock |
| rst_b | input | 1 | B-side synchronous reset, active high |
| b_sel_n | input | 1 | B-side select, active low |
| b_rd_nwr | input | 1 | B-side direction, 0 = write |
| b_en | input | 1 | B-side transfer enable |
| b_mbx | input | 1 | B-side mailbox select |
| b_din | input | DATA_W | B-side write data |
| b_fifo_q | input | DATA_W | Queue output register for the B side |
| b_dout | output | DATA_W | B-side read data |
| b_mail_full_n | output | 1 | Return box full flag, active low |

## Verification
If a flag sticks low, every later post to that box is dropped, and the far port's data output keeps the old word from the next writer edge onward. If a fetch toggle is lost or doubled in the synchronizer, the flag fails to rise two writer edges after the fetch. A stale release pulse would clear a flag that a new post has just set, and that shows on the flag pin one cycle after the post. Corrupted box contents appear on the far port's output as soon as its mailbox select is high, with no fetch needed.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Control strobe of one port, gathered into one word.
    typedef struct packed {
        logic sel_n;
        logic dir;
        logic en;
        logic mbx;
    } port_ctl_t;

    typedef enum logic [2:0] {
        XF_IDLE,
        XF_FIFO_WR,
        XF_FIFO_RD,
        XF_MAIL_WR,
        XF_MAIL_RD
    } xfer_e;

    // Fewest synchronizer flops allowed on a crossing.
    localparam int MIN_SYNC = 2;

    function automatic xfer_e classify(input port_ctl_t c, input logic wr_level);
        if (c.sel_n || !c.en) begin
            return XF_IDLE;
        end
        if (c.dir == wr_level) begin
            return c.mbx ? XF_MAIL_WR : XF_FIFO_WR;
        end
        return c.mbx ? XF_MAIL_RD : XF_FIFO_RD;
    endfunction

endpackage

// File: rtl/mbx_port_ctl.sv
module mbx_port_ctl
    import mbx_pkg::*;
#(
    parameter logic WR_LEVEL = 1'b1
) (
    input  port_ctl_t ctl,
    output logic      mail_wr,
    output logic      mail_rd
);
    xfer_e kind;

    assign kind    = classify(ctl, WR_LEVEL);
    assign mail_wr = (kind == XF_MAIL_WR);
    assign mail_rd = (kind == XF_MAIL_RD);
endmodule

// File: rtl/mbx_rd_notify.sv
module mbx_rd_notify (
    input  logic clk,
    input  logic rst,
    input  logic rd_req,
    output logic rd_tog
);
    // Each fetch flips the level that the writer domain watches.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_tog <= 1'b0;
        end else if (rd_req) begin
            rd_tog <= ~rd_tog;
        end
    end
endmodule

// File: rtl/mbx_tog_sync.sv
module mbx_tog_sync
    import mbx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tog_in,
    output logic edge_seen
);
    localparam int DEPTH = (STAGES < MIN_SYNC) ? MIN_SYNC : STAGES;

    // chain[DEPTH-1] is the synchronized level; chain[DEPTH] is its prior value.
    logic [DEPTH:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[DEPTH-1:0], tog_in};
        end
    end

    assign edge_seen = chain[DEPTH] ^ chain[DEPTH-1];
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
    parameter int DATA_W = 36,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_tog,
    output logic [DATA_W-1:0] word_q,
    output logic              full_n
);
    logic flag_q;
    logic release_now;
    logic accept;

    mbx_tog_sync #(.STAGES(STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .tog_in    (rd_tog),
        .edge_seen (release_now)
    );

    // A release that has just arrived frees the box on this edge.
    assign full_n = flag_q | release_now;
    assign accept = wr_req & full_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            flag_q <= 1'b1;
        end else if (accept) begin
            word_q <= wr_data;
            flag_q <= 1'b0;
        end else if (release_now) begin
            flag_q <= 1'b1;
        end
    end
endmodule

// File: rtl/mbx_out_mux.sv
module mbx_out_mux #(
    parameter int DATA_W = 36
) (
    input  logic              use_mail,
    input  logic [DATA_W-1:0] fifo_q,
    input  logic [DATA_W-1:0] mail_q,
    output logic [DATA_W-1:0] dout
);
    always_comb begin
        dout = use_mail ? mail_q : fifo_q;
    end
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
    import mbx_pkg::*;
#(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              rst_a,
    input  logic              a_sel_n,
    input  logic              a_wr,
    input  logic              a_en,
    input  logic              a_mbx,
    input  logic [DATA_W-1:0] a_din,
    input  logic [DATA_W-1:0] a_fifo_q,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_mail_full_n,
    input  logic              clk_b,
    input  logic              rst_b,
    input  logic              b_sel_n,
    input  logic              b_rd_nwr,
    input  logic              b_en,
    input  logic              b_mbx,
    input  logic [DATA_W-1:0] b_din,
    input  logic [DATA_W-1:0] b_fifo_q,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_mail_full_n
);
    port_ctl_t         a_ctl, b_ctl;
    logic              a_mail_wr, a_mail_rd;
    logic              b_mail_wr, b_mail_rd;
    logic              a_rd_tog, b_rd_tog;
    logic [DATA_W-1:0] mail1_q, mail2_q;

    assign a_ctl = '{sel_n: a_sel_n, dir: a_wr,     en: a_en, mbx: a_mbx};
    assign b_ctl = '{sel_n: b_sel_n, dir: b_rd_nwr, en: b_en, mbx: b_mbx};

    // A writes with direction high; B writes with direction low.
    mbx_port_ctl #(.WR_LEVEL(1'b1)) u_ctl_a (
        .ctl (a_ctl), .mail_wr (a_mail_wr), .mail_rd (a_mail_rd)
    );
    mbx_port_ctl #(.WR_LEVEL(1'b0)) u_ctl_b (
        .ctl (b_ctl), .mail_wr (b_mail_wr), .mail_rd (b_mail_rd)
    );

    // Fetch notifications leave the reader's domain as toggles.
    mbx_rd_notify u_note_b (
        .clk (clk_b), .rst (rst_b), .rd_req (b_mail_rd), .rd_tog (b_rd_tog)
    );
    mbx_rd_notify u_note_a (
        .clk (clk_a), .rst (rst_a), .rd_req (a_mail_rd), .rd_tog (a_rd_tog)
    );

    // Forward box: written and flagged in the A domain.
    mbx_slot #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_slot_fwd (
        .clk     (clk_a),
        .rst     (rst_a),
        .wr_req  (a_mail_wr),
        .wr_data (a_din),
        .rd_tog  (b_rd_tog),
        .word_q  (mail1_q),
        .full_n  (a_mail_full_n)
    );

    // Return box: written and flagged in the B domain.
    mbx_slot #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_slot_ret (
        .clk     (clk_b),
        .rst     (rst_b),
        .wr_req  (b_mail_wr),
        .wr_data (b_din),
        .rd_tog  (a_rd_tog),
        .word_q  (mail2_q),
        .full_n  (b_mail_full_n)
    );

    mbx_out_mux #(.DATA_W(DATA_W)) u_mux_a (
        .use_mail (a_mbx), .fifo_q (a_fifo_q), .mail_q (mail2_q), .dout (a_dout)
    );
    mbx_out_mux #(.DATA_W(DATA_W)) u_mux_b (
        .use_mail (b_mbx), .fifo_q (b_fifo_q), .mail_q (mail1_q), .dout (b_dout)
    );
endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk_a,
    input logic              rst_a,
    input logic              a_mail_wr,
    input logic              a_mail_full_n,
    input logic [DATA_W-1:0] a_din,
    input logic [DATA_W-1:0] mail1,
    input logic              clk_b,
    input logic              rst_b,
    input logic              b_mail_wr,
    input logic              b_mail_full_n,
    input logic [DATA_W-1:0] b_din,
    input logic [DATA_W-1:0] mail2
);
    p_load_r1: assert property (@(posedge clk_a) disable iff (rst_a)
        a_mail_wr && a_mail_full_n |=> mail1 == $past(a_din) && !a_mail_full_n);

    p_load_r2: assert property (@(posedge clk_b) disable iff (rst_b)
        b_mail_wr && b_mail_full_n |=> mail2 == $past(b_din) && !b_mail_full_n);

    p_drop_fwd_r3: assert property (@(posedge clk_a) disable iff (rst_a)
        a_mail_wr && !a_mail_full_n |=> $stable(mail1));

    p_drop_ret_r3: assert property (@(posedge clk_b) disable iff (rst_b)
        b_mail_wr && !b_mail_full_n |=> $stable(mail2));

    p_keep_fwd_r7: assert property (@(posedge clk_a) disable iff (rst_a)
        !a_mail_wr |=> $stable(mail1));

    p_keep_ret_r7: assert property (@(posedge clk_b) disable iff (rst_b)
        !b_mail_wr |=> $stable(mail2));

    p_reset_fwd_r8: assert property (@(posedge clk_a)
        rst_a |=> a_mail_full_n && mail1 == '0);

    p_reset_ret_r8: assert property (@(posedge clk_b)
        rst_b |=> b_mail_full_n && mail2 == '0);
endmodule

bind mbx_bridge mbx_bridge_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_a         (clk_a),
    .rst_a         (rst_a),
    .a_mail_wr     (a_mail_wr),
    .a_mail_full_n (a_mail_full_n),
    .a_din         (a_din),
    .mail1         (mail1_q),
    .clk_b         (clk_b),
    .rst_b         (rst_b),
    .b_mail_wr     (b_mail_wr),
    .b_mail_full_n (b_mail_full_n),
    .b_din         (b_din),
    .mail2         (mail2_q)
);

// File: tb/tb_mbx_bridge.sv
module tb_mbx_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_B_HALF = 7;
    localparam int W          = 36;

    localparam int OP_W     = 0;  // post to forward box
    localparam int OP_WFIFO = 1;  // write with mailbox select low
    localparam int OP_BRD   = 2;  // B-side fetch of forward box
    localparam int OP_WSEL  = 3;  // write with select high
    localparam int OP_WEN   = 4;  // write with enable low
    localparam int OP_ARD   = 5;  // A-side fetch direction

    localparam int NV = 9;
    localparam int     V_OP [NV] = '{OP_W, OP_W, OP_WFIFO, OP_BRD, OP_WSEL,
                                     OP_WEN, OP_ARD, OP_W, OP_BRD};
    localparam logic [W-1:0] V_DIN [NV] = '{36'h123456789, 36'hAAAAAAAAA,
        36'h555555555, 36'h0, 36'h0F0F0F0F0, 36'h0F0F0F0F0, 36'h0,
        36'hFEDCBA987, 36'h0};
    localparam logic [W-1:0] V_MAIL [NV] = '{36'h123456789, 36'h123456789,
        36'h123456789, 36'h123456789, 36'h123456789, 36'h123456789,
        36'h123456789, 36'hFEDCBA987, 36'hFEDCBA987};
    localparam logic V_FULLN [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1,
                                      1'b1, 1'b0, 1'b1};
    localparam string V_REQ [NV] = '{"R1", "R3", "R9", "R4", "R9", "R9",
                                     "R9", "R1", "R7"};

    logic         clk_a = 1'b0, clk_b = 1'b0;
    logic         rst_a = 1'b1, rst_b = 1'b1;
    logic         a_sel_n = 1'b1, a_wr = 1'b0, a_en = 1'b0, a_mbx = 1'b0;
    logic         b_sel_n = 1'b1, b_rd_nwr = 1'b1, b_en = 1'b0, b_mbx = 1'b0;
    logic [W-1:0] a_din = '0, a_fifo_q = '0, b_din = '0, b_fifo_q = '0;
    logic [W-1:0] a_dout, b_dout;
    logic         a_mail_full_n, b_mail_full_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk_a = ~clk_a;
    initial begin
        #1;
        forever #(CLK_B_HALF) clk_b = ~clk_b;
    end

    mbx_bridge #(.DATA_W(W), .SYNC_STAGES(2)) dut (
        .clk_a (clk_a), .rst_a (rst_a), .a_sel_n (a_sel_n), .a_wr (a_wr),
        .a_en (a_en), .a_mbx (a_mbx), .a_din (a_din), .a_fifo_q (a_fifo_q),
        .a_dout (a_dout), .a_mail_full_n (a_mail_full_n),
        .clk_b (clk_b), .rst_b (rst_b), .b_sel_n (b_sel_n),
        .b_rd_nwr (b_rd_nwr), .b_en (b_en), .b_mbx (b_mbx), .b_din (b_din),
        .b_fifo_q (b_fifo_q), .b_dout (b_dout), .b_mail_full_n (b_mail_full_n)
    );

    task automatic chk(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic do_reset();
        rst_a = 1'b1;
        rst_b = 1'b1;
        repeat (4) @(posedge clk_b);
        @(negedge clk_a) rst_a = 1'b0;
        @(negedge clk_b) rst_b = 1'b0;
        @(posedge clk_a);
        #1;
    endtask

    task automatic a_strobe(input int op, input logic [W-1:0] d);
        @(negedge clk_a);
        a_sel_n = (op == OP_WSEL);
        a_en    = (op != OP_WEN);
        a_wr    = (op != OP_ARD);
        a_mbx   = (op != OP_WFIFO);
        a_din   = d;
        @(posedge clk_a);
        a_en    <= 1'b0;
        a_sel_n <= 1'b1;
        #1;
    endtask

    // B fetch of the forward box, then the two-edge release check (R4).
    task automatic b_fetch_fwd();
        @(negedge clk_b);
        b_sel_n  = 1'b0;
        b_rd_nwr = 1'b1;
        b_en     = 1'b1;
        b_mbx    = 1'b1;
        @(posedge clk_b);
        b_en    <= 1'b0;
        b_sel_n <= 1'b1;
        @(posedge clk_a);
        #1 chk("R4 flag after first edge", W'(a_mail_full_n), W'(1'b0));
        @(posedge clk_a);
        #1;
    endtask

    task automatic b_post(input logic [W-1:0] d);
        @(negedge clk_b);
        b_sel_n  = 1'b0;
        b_rd_nwr = 1'b0;
        b_en     = 1'b1;
        b_mbx    = 1'b1;
        b_din    = d;
        @(posedge clk_b);
        b_en    <= 1'b0;
        b_sel_n <= 1'b1;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk_a);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        summary();
    end

    initial begin
        do_reset();
        a_mbx = 1'b1;
        b_mbx = 1'b1;
        #1;
        // R8: reset state
        chk("R8 fwd flag", W'(a_mail_full_n), W'(1'b1));
        chk("R8 ret flag", W'(b_mail_full_n), W'(1'b1));
        chk("R8 fwd box", b_dout, '0);
        chk("R8 ret box", a_dout, '0);

        // Vector walk over the forward box.
        for (int i = 0; i < NV; i++) begin
            if (V_OP[i] == OP_BRD) begin
                b_fetch_fwd();
            end else begin
                a_strobe(V_OP[i], V_DIN[i]);
            end
            b_mbx = 1'b1;
            #1;
            chk({V_REQ[i], " flag"}, W'(a_mail_full_n), W'(V_FULLN[i]));
            chk({V_REQ[i], " box"}, b_dout, V_MAIL[i]);
        end

        // R6: queue path on both outputs
        a_mbx = 1'b0;
        b_mbx = 1'b0;
        a_fifo_q = 36'hC3C3C3C3C;
        b_fifo_q = 36'h3C3C3C3C3;
        #1;
        chk("R6 a_dout queue", a_dout, 36'hC3C3C3C3C);
        chk("R6 b_dout queue", b_dout, 36'h3C3C3C3C3);
        a_mbx = 1'b1;
        b_mbx = 1'b1;
        #1;
        chk("R6 b_dout mail", b_dout, 36'hFEDCBA987);

        // R2 / R3 on the return box
        b_post(36'h0BADC0FFE);
        chk("R2 ret flag", W'(b_mail_full_n), W'(1'b0));
        chk("R2 ret box", a_dout, 36'h0BADC0FFE);
        b_post(36'h111111111);
        chk("R3 ret flag", W'(b_mail_full_n), W'(1'b0));
        chk("R3 ret box", a_dout, 36'h0BADC0FFE);

        // R5: A fetch releases the return box two clk_b edges later
        @(negedge clk_a);
        a_sel_n = 1'b0;
        a_wr    = 1'b0;
        a_en    = 1'b1;
        a_mbx   = 1'b1;
        @(posedge clk_a);
        a_en    <= 1'b0;
        a_sel_n <= 1'b1;
        @(posedge clk_b);
        #1 chk("R5 flag after first edge", W'(b_mail_full_n), W'(1'b0));
        @(posedge clk_b);
        #1 chk("R5 flag after second edge", W'(b_mail_full_n), W'(1'b1));
        chk("R7 ret box after fetch", a_dout, 36'h0BADC0FFE);

        // R10: post on the very next writer edge
        b_post(36'h222222222);
        chk("R10 flag", W'(b_mail_full_n), W'(1'b0));
        chk("R10 box", a_dout, 36'h222222222);
        @(posedge clk_b);
        @(posedge clk_b);
        #1 chk("R10 flag stays low", W'(b_mail_full_n), W'(1'b0));

        // R8: reset while both boxes are full
        a_strobe(OP_W, 36'h777777777);
        chk("R1 pre-reset post", b_dout, 36'h777777777);
        do_reset();
        #1;
        chk("R8 fwd flag again", W'(a_mail_full_n), W'(1'b1));
        chk("R8 ret flag again", W'(b_mail_full_n), W'(1'b1));
        chk("R8 fwd box again", b_dout, '0);
        chk("R8 ret box again", a_dout, '0);

        summary();
    end
endmodule